// File: doc/BRIEF.md
# Three-Area Banked Address Translator

This block relocates a 16-bit logical address into a 19-bit physical address space. The logical space is cut at two programmable 4 KB page boundaries into three regions: a low common region, a bank region in the middle, and an upper common region. A logical address in the low region passes through unchanged. An address in the bank region or the upper region gets its own 8-bit base register added to it. That base is counted in 4 KB pages, so it is shifted left by twelve bits before the add.

Software programs three 8-bit registers through a simple I/O port: an upper-common base, a bank base and a boundary register. The boundary register holds two page numbers. Its low nibble is the first page of the bank region, and its high nibble is the first page of the upper common region. The translation itself is purely combinational. A 2-bit region code is brought out beside the physical address so that tests can observe which region was selected.

Top module: `banked_addr_xlate`

## Requirements
- R1: After reset, the upper-common base (I/O 0x38) and the bank base (I/O 0x39) read back 0x00, and the boundary register (I/O 0x3A) reads back 0xFF.
- R2: When ioWrEn is high at a rising clock edge and ioAddr is 0x38, 0x39 or 0x3A, ioWrData is stored in the matching register. From the next cycle on, ioRdData shows that register's contents combinationally whenever ioAddr selects it.
- R3: Any other I/O address reads as 0x00. Writes to any other I/O address leave all three registers unchanged.
- R4: Let the logical page be logAddr[15:12]. If it is below the bank start (boundary bits 3:0), areaCode is 0 and physAddr equals logAddr zero-extended to 19 bits.
- R5: If the logical page is at or above the bank start and below the upper start (boundary bits 7:4), areaCode is 1 and physAddr is (logAddr + bankBase*4096) mod 2^19.
- R6: If the logical page is at or above the upper start, areaCode is 2 and physAddr is (logAddr + commonBase*4096) mod 2^19. Logical page 0xF therefore always maps to region 2.
- R7: If the bank start is not below the upper start, the bank region is empty. The upper-start comparison wins, and areaCode 1 never appears.
- R8: areaCode never takes the value 3, and physAddr[11:0] always equals logAddr[11:0].
- R9: physAddr and areaCode follow a change of logAddr in the same cycle, with no clock edge. They also reflect a register write from the cycle after that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioAddr | input | 8 | I/O register address |
| ioWrEn | input | 1 | Write strobe, sampled at the rising edge |
| ioWrData | input | 8 | Write data |
| ioRdData | output | 8 | Read data for ioAddr, or zero if ioAddr is unmapped |
| logAddr | input | 16 | Logical address to translate |
| physAddr | output | 19 | Translated physical address |
| areaCode | output | 2 | Selected region: 0 low common, 1 bank, 2 upper common |

## Verification
Only the three registers hold state. A corrupted boundary nibble shows up as a wrong areaCode on the first logical page that straddles the true and false boundary. A corrupted base shows up as wrong physAddr bits 18:12 for any address in that region. Either error is visible in the cycle after the bad write, and the I/O read port exposes it as soon as the register is addressed. The bench sweeps every boundary value against every logical page under several base pairs, so a misplaced comparison or a swapped base selection is caught within one configuration.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  typedef enum logic [1:0] {
    AREA_LOW   = 2'd0,
    AREA_BANK  = 2'd1,
    AREA_UPPER = 2'd2
  } area_e;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_COMMON = 2'd1,
    RD_BANK   = 2'd2,
    RD_BOUND  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrCommon;
    logic   wrBank;
    logic   wrBound;
    rdSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
#(
  parameter int              IO_W      = 8,
  parameter logic [IO_W-1:0] COMMON_IO = 'h38,
  parameter logic [IO_W-1:0] BANK_IO   = 'h39,
  parameter logic [IO_W-1:0] BOUND_IO  = 'h3A
) (
  input  logic [IO_W-1:0] ioAddr,
  input  logic            ioWrEn,
  output regStrobe_t      strobe
);

  always_comb begin
    strobe.wrCommon = 1'b0;
    strobe.wrBank   = 1'b0;
    strobe.wrBound  = 1'b0;
    strobe.rdSel    = RD_NONE;
    if (ioAddr == COMMON_IO) begin
      strobe.wrCommon = ioWrEn;
      strobe.rdSel    = RD_COMMON;
    end else if (ioAddr == BANK_IO) begin
      strobe.wrBank = ioWrEn;
      strobe.rdSel  = RD_BANK;
    end else if (ioAddr == BOUND_IO) begin
      strobe.wrBound = ioWrEn;
      strobe.rdSel   = RD_BOUND;
    end
  end

endmodule

// File: rtl/xlate_dpath.sv
module xlate_dpath
  import xlate_pkg::*;
#(
  parameter int LOG_W  = 16,
  parameter int PHYS_W = 19,
  parameter int PAGE_W = 4,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [REG_W-1:0]  ioWrData,
  output logic [REG_W-1:0]  ioRdData,
  input  logic [LOG_W-1:0]  logAddr,
  output logic [PHYS_W-1:0] physAddr,
  output area_e             areaCode
);

  localparam int OFFS_W = LOG_W - PAGE_W;

  logic [REG_W-1:0]  commonBase;
  logic [REG_W-1:0]  bankBase;
  logic [REG_W-1:0]  bound;
  logic [PAGE_W-1:0] bankStart;
  logic [PAGE_W-1:0] upperStart;
  logic [PAGE_W-1:0] logPage;
  logic [REG_W-1:0]  selBase;

  // The boundary register holds two page numbers side by side.
  generate
    if (REG_W == 2 * PAGE_W) begin : g_split
      assign bankStart  = bound[PAGE_W-1:0];
      assign upperStart = bound[2*PAGE_W-1:PAGE_W];
    end else begin : g_split_bad
      initial $error("REG_W must hold two page nibbles");
      assign bankStart  = '1;
      assign upperStart = '1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      commonBase <= '0;
      bankBase   <= '0;
      bound      <= '1;
    end else begin
      if (strobe.wrCommon) commonBase <= ioWrData;
      if (strobe.wrBank)   bankBase   <= ioWrData;
      if (strobe.wrBound)  bound      <= ioWrData;
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      RD_COMMON: ioRdData = commonBase;
      RD_BANK:   ioRdData = bankBase;
      RD_BOUND:  ioRdData = bound;
      default:   ioRdData = '0;
    endcase
  end

  assign logPage = logAddr[LOG_W-1:OFFS_W];

  // The upper compare comes first, so an empty bank region yields to it.
  always_comb begin
    if (logPage >= upperStart) begin
      areaCode = AREA_UPPER;
      selBase  = commonBase;
    end else if (logPage >= bankStart) begin
      areaCode = AREA_BANK;
      selBase  = bankBase;
    end else begin
      areaCode = AREA_LOW;
      selBase  = '0;
    end
  end

  assign physAddr = PHYS_W'(logAddr) + (PHYS_W'(selBase) << OFFS_W);

endmodule

// File: rtl/banked_addr_xlate.sv
module banked_addr_xlate
  import xlate_pkg::*;
#(
  parameter int              IO_W      = 8,
  parameter int              LOG_W     = 16,
  parameter int              PHYS_W    = 19,
  parameter int              PAGE_W    = 4,
  parameter int              REG_W     = 8,
  parameter logic [IO_W-1:0] COMMON_IO = 'h38,
  parameter logic [IO_W-1:0] BANK_IO   = 'h39,
  parameter logic [IO_W-1:0] BOUND_IO  = 'h3A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IO_W-1:0]   ioAddr,
  input  logic              ioWrEn,
  input  logic [REG_W-1:0]  ioWrData,
  output logic [REG_W-1:0]  ioRdData,
  input  logic [LOG_W-1:0]  logAddr,
  output logic [PHYS_W-1:0] physAddr,
  output logic [1:0]        areaCode
);

  regStrobe_t strobe;
  area_e      areaSel;

  xlate_ctrl #(
    .IO_W(IO_W), .COMMON_IO(COMMON_IO), .BANK_IO(BANK_IO), .BOUND_IO(BOUND_IO)
  ) u_ctrl (
    .ioAddr(ioAddr),
    .ioWrEn(ioWrEn),
    .strobe(strobe)
  );

  xlate_dpath #(
    .LOG_W(LOG_W), .PHYS_W(PHYS_W), .PAGE_W(PAGE_W), .REG_W(REG_W)
  ) u_dpath (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .ioWrData(ioWrData),
    .ioRdData(ioRdData),
    .logAddr(logAddr),
    .physAddr(physAddr),
    .areaCode(areaSel)
  );

  assign areaCode = areaSel;

endmodule

// File: rtl/xlate_checker.sv
module xlate_checker #(
  parameter int              IO_W      = 8,
  parameter int              LOG_W     = 16,
  parameter int              PHYS_W    = 19,
  parameter int              PAGE_W    = 4,
  parameter int              REG_W     = 8,
  parameter logic [IO_W-1:0] COMMON_IO = 'h38,
  parameter logic [IO_W-1:0] BANK_IO   = 'h39,
  parameter logic [IO_W-1:0] BOUND_IO  = 'h3A
) (
  input logic              clk,
  input logic              rstN,
  input logic [IO_W-1:0]   ioAddr,
  input logic              ioWrEn,
  input logic [REG_W-1:0]  ioWrData,
  input logic [REG_W-1:0]  ioRdData,
  input logic [LOG_W-1:0]  logAddr,
  input logic [PHYS_W-1:0] physAddr,
  input logic [1:0]        areaCode
);

  localparam int OFFS_W = LOG_W - PAGE_W;

  logic mapped;
  assign mapped = (ioAddr == COMMON_IO) || (ioAddr == BANK_IO) || (ioAddr == BOUND_IO);

  p_area_legal_r8: assert property (@(posedge clk) disable iff (!rstN)
    areaCode != 2'd3);

  p_offset_pass_r8: assert property (@(posedge clk) disable iff (!rstN)
    physAddr[OFFS_W-1:0] == logAddr[OFFS_W-1:0]);

  p_low_identity_r4: assert property (@(posedge clk) disable iff (!rstN)
    (areaCode == 2'd0) |-> (physAddr == PHYS_W'(logAddr)));

  p_top_page_upper_r6: assert property (@(posedge clk) disable iff (!rstN)
    (logAddr[LOG_W-1:OFFS_W] == '1) |-> (areaCode == 2'd2));

  p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    !mapped |-> (ioRdData == '0));

  p_write_visible_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrEn && ioAddr == BANK_IO) |=> ((ioAddr == BANK_IO) |-> (ioRdData == $past(ioWrData))));

  p_hold_without_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ioWrEn |=> ($stable(ioAddr) |-> $stable(ioRdData)));

endmodule

bind banked_addr_xlate xlate_checker #(
  .IO_W(IO_W), .LOG_W(LOG_W), .PHYS_W(PHYS_W), .PAGE_W(PAGE_W), .REG_W(REG_W),
  .COMMON_IO(COMMON_IO), .BANK_IO(BANK_IO), .BOUND_IO(BOUND_IO)
) u_chk (
  .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrEn(ioWrEn), .ioWrData(ioWrData),
  .ioRdData(ioRdData), .logAddr(logAddr), .physAddr(physAddr), .areaCode(areaCode)
);

// File: tb/test_banked_addr_xlate.sv
`timescale 1ns/1ps
module test_banked_addr_xlate;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  ioAddr = 8'h00;
  logic        ioWrEn = 1'b0;
  logic [7:0]  ioWrData = 8'h00;
  logic [7:0]  ioRdData;
  logic [15:0] logAddr = 16'h0000;
  logic [18:0] physAddr;
  logic [1:0]  areaCode;

  int checks = 0;
  int errors = 0;

  logic [7:0] cbV, bbV, bndV;

  always #2 clk = ~clk;

  banked_addr_xlate i_banked_addr_xlate (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrEn(ioWrEn), .ioWrData(ioWrData),
    .ioRdData(ioRdData), .logAddr(logAddr), .physAddr(physAddr), .areaCode(areaCode)
  );

  task automatic ioWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioWrData = d; ioWrEn = 1'b1;
    @(negedge clk);
    ioWrEn = 1'b0;
  endtask

  task automatic checkRead(input logic [7:0] a, input logic [7:0] exp, input string req);
    ioAddr = a;
    #1;
    checks++;
    if (ioRdData !== exp) begin
      errors++;
      $display("FAIL %s read 0x%02h got 0x%02h expected 0x%02h", req, a, ioRdData, exp);
    end
  endtask

  task automatic checkXlate(input logic [15:0] la, input string reqIn);
    logic [3:0]  pg;
    logic [19:0] sum;
    logic [18:0] expPa;
    logic [1:0]  expAc;
    string       req;
    pg = la[15:12];
    if (pg >= bndV[7:4]) begin
      expAc = 2'd2; sum = {4'h0, la} + {cbV, 12'h000}; req = "R6";
    end else if (pg >= bndV[3:0]) begin
      expAc = 2'd1; sum = {4'h0, la} + {bbV, 12'h000}; req = "R5";
    end else begin
      expAc = 2'd0; sum = {4'h0, la}; req = "R4";
    end
    if (bndV[3:0] >= bndV[7:4]) req = {req, "/R7"};
    if (reqIn != "") req = {req, "/", reqIn};
    expPa = sum[18:0];
    logAddr = la;
    #1;
    checks++;
    if (physAddr !== expPa || areaCode !== expAc) begin
      errors++;
      $display("FAIL %s/R8 bnd=%02h la=%04h got pa=%05h ac=%0d expected pa=%05h ac=%0d",
               req, bndV, la, physAddr, areaCode, expPa, expAc);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cbV = 8'h00; bbV = 8'h00; bndV = 8'hFF;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset contents, observed while reset is still asserted
    checkRead(8'h38, 8'h00, "R1");
    checkRead(8'h39, 8'h00, "R1");
    checkRead(8'h3A, 8'hFF, "R1");
    @(negedge clk);
    rstN = 1'b1;
    // R1 with R4 and R6: the default map is identity everywhere
    for (int p = 0; p < 16; p++) checkXlate(16'(p * 4096 + p * 17), "R1");

    // R2: write and read back each register
    ioWrite(8'h38, 8'hA5); cbV = 8'hA5;
    ioWrite(8'h39, 8'h3C); bbV = 8'h3C;
    ioWrite(8'h3A, 8'h84); bndV = 8'h84;
    checkRead(8'h38, 8'hA5, "R2");
    checkRead(8'h39, 8'h3C, "R2");
    checkRead(8'h3A, 8'h84, "R2");

    // R3: unmapped writes are ignored and unmapped reads return zero
    ioWrite(8'h37, 8'h11);
    ioWrite(8'h3B, 8'h22);
    ioWrite(8'hB9, 8'h33);
    ioWrite(8'h00, 8'h44);
    checkRead(8'h38, 8'hA5, "R3");
    checkRead(8'h39, 8'h3C, "R3");
    checkRead(8'h3A, 8'h84, "R3");
    checkRead(8'h37, 8'h00, "R3");
    checkRead(8'h3B, 8'h00, "R3");
    checkRead(8'hB9, 8'h00, "R3");

    // R9: the output follows logAddr with no clock edge in between
    @(negedge clk);
    checkXlate(16'h1234, "R9");
    checkXlate(16'h5678, "R9");
    checkXlate(16'h9ABC, "R9");
    // R9: a write shows in the translation from the next cycle
    logAddr = 16'h5001;
    ioWrite(8'h39, 8'hF7); bbV = 8'hF7;
    checkXlate(16'h5001, "R9");

    // Sweep every boundary value and every logical page under several base pairs
    for (int b = 0; b < 3; b++) begin
      logic [7:0] cbs, bbs;
      cbs = (b == 0) ? 8'h00 : (b == 1) ? 8'hC3 : 8'hFF;
      bbs = (b == 0) ? 8'h01 : (b == 1) ? 8'h5A : 8'h81;
      ioWrite(8'h38, cbs); cbV = cbs;
      ioWrite(8'h39, bbs); bbV = bbs;
      for (int bd = 0; bd < 256; bd++) begin
        ioWrite(8'h3A, 8'(bd)); bndV = 8'(bd);
        for (int p = 0; p < 16; p++) begin
          checkXlate(16'(p * 4096 + ((bd * 37 + p * 291 + b * 1000) % 4096)), "");
        end
      end
    end
    // R2: the last swept value reads back
    checkRead(8'h3A, 8'hFF, "R2");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule